// File: doc/BRIEF.md
# Selectable-Width Serial Word Shifter

This block is the read-side back end of a word queue. It takes the 9-bit word at the head of the queue and delivers it in one of two ways. In serial mode the word goes into a shift register and leaves one bit at a time on a single output. In parallel mode the whole word is held on a 9-bit output bus. The serial word length can be changed at run time to any value from 1 to 9 bits. A new word is requested from the queue once per programmed number of serial steps.

The queue is show-ahead. `rd_data` carries the head word whenever `fifo_nonempty` is high, and a one-cycle `rd_req` pops that word. A serial step is a one-cycle pulse on `sclk_en`. A cascade input can stall a chain of instances that together form a wider word, and a cascade output marks the last bit of the word being sent.

An output-enable input gates only the parallel bus. In serial mode, if the queue is empty when a new word is needed, the serial output holds its last bit and an underrun flag is raised.

Top module: `wsh_word_shifter`

## Requirements
- R1: While `rst_n` is low, the outputs `rd_req`, `ser_out`, `underrun`, `casc_out` and `par_valid` are 0 and `par_data` is all zero. This holds immediately when `rst_n` falls, with no clock edge needed. After `rst_n` rises, the block starts working on the third rising clock edge.
- R2: In serial mode (`par_mode`=0), when no word is held and `fifo_nonempty` is 1, the block loads `rd_data` and pulses `rd_req` without waiting for a step. Bit 0 of the loaded word appears on `ser_out` in the cycle after the load.
- R3: A serial step is `sclk_en`=1 while `casc_in`=1. Each serial step that does not end the word moves `ser_out` to the next more significant bit, so bits leave least-significant first.
- R4: `width_sel` sets the serial word length: codes 1 to 9 give that many bits, code 0 gives 1 bit, and codes 10 to 15 give 9 bits. The length is captured when a word is loaded. Later changes to `width_sel` affect only the next word. Exactly one `rd_req` is issued per word.
- R5: `rd_req` is only ever 1 while `fifo_nonempty` is 1.
- R6: A serial step at the last bit of a word, or while no word is held, finds the queue empty. It then sets `underrun` to 1, and `ser_out` keeps its value until the next load. The next load clears `underrun`.
- R7: While `casc_in` is 0, `sclk_en` pulses in serial mode leave `ser_out` unchanged and cause no `rd_req`.
- R8: In serial mode, `casc_out` is 1 exactly while the held word is showing its last bit.
- R9: In parallel mode (`par_mode`=1), each `sclk_en` pulse with a non-empty queue pops one word into the parallel register. Nothing is loaded without a pulse. A pulse while the queue is empty leaves the register unchanged and issues no `rd_req`.
- R10: `par_valid` is 1 only when all three hold: the block is in parallel mode, the parallel register holds a word, and `oe_n` is 0. `par_data` shows that word while `par_valid` is 1 and is all zero otherwise. `oe_n` has no effect on the serial path.
- R11: In parallel mode, the serial shift register is not changed, so `ser_out` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| par_mode | input | 1 | 1 = parallel output, 0 = serial output |
| oe_n | input | 1 | Active-low enable for the parallel bus |
| sclk_en | input | 1 | Serial step pulse in serial mode; word strobe in parallel mode |
| casc_in | input | 1 | Cascade enable; tie high for a single instance |
| width_sel | input | 4 | Serial word length code |
| fifo_nonempty | input | 1 | High while the queue holds a word |
| rd_data | input | 9 | Head word of the queue |
| rd_req | output | 1 | Pops the head word of the queue |
| ser_out | output | 1 | Serial data output |
| underrun | output | 1 | Serial output starved for data |
| casc_out | output | 1 | Last bit of the serial word is being shown |
| par_data | output | 9 | Parallel word, zero while not valid |
| par_valid | output | 1 | Parallel word qualifier |

## Verification
The assertions check on every cycle that:
- a pop is never requested from an empty queue;
- the parallel bus is quiet while `oe_n` is high;
- a parallel-mode pop always comes with a strobe;
- the serial output is frozen during an underrun and while in parallel mode.

Some behaviours need whole streams and only the bench scenarios can show them:
- the least-significant-first bit order;
- the mapping of width codes to lengths, including the clamped codes 0 and 15;
- the length being captured at load time;
- the count of one request per word;
- the position of the cascade marker;
- the stall caused by the cascade input.

// File: rtl/wsh_pkg.sv
`timescale 1ns/1ps
package wsh_pkg;
  typedef enum logic {
    WSH_SERIAL   = 1'b0,
    WSH_PARALLEL = 1'b1
  } wsh_mode_e;
endpackage

// File: rtl/wsh_rst_sync.sv
`timescale 1ns/1ps
module wsh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wsh_width_dec.sv
`timescale 1ns/1ps
module wsh_width_dec #(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic [CNT_W-1:0] code,
  output logic [CNT_W-1:0] width
);
  localparam logic [CNT_W-1:0] MAX_W = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] MIN_W = CNT_W'(1);

  always_comb begin
    if (code == '0)        width = MIN_W;
    else if (code > MAX_W) width = MAX_W;
    else                   width = code;
  end
endmodule

// File: rtl/wsh_ser_ctrl.sv
`timescale 1ns/1ps
module wsh_ser_ctrl #(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ser_mode,
  input  logic             step,
  input  logic             nonempty,
  input  logic [CNT_W-1:0] width,
  output logic             load,
  output logic             shift,
  output logic             last_bit,
  output logic             underrun
);
  logic             full_q, full_d;
  logic             unr_q, unr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             need_word;

  assign last_bit  = full_q && (left_q == CNT_W'(1));
  assign need_word = !full_q || (step && last_bit);
  assign load      = run && ser_mode && nonempty && need_word;
  assign shift     = run && ser_mode && step && full_q && !last_bit;
  assign underrun  = unr_q;

  always_comb begin
    full_d = full_q;
    unr_d  = unr_q;
    left_d = left_q;
    if (load) begin
      full_d = 1'b1;
      unr_d  = 1'b0;
      left_d = width;
    end else if (ser_mode && step && need_word) begin
      full_d = 1'b0;
      unr_d  = 1'b1;
    end else if (shift) begin
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      unr_q  <= 1'b0;
      left_q <= '0;
    end else if (run) begin
      full_q <= full_d;
      unr_q  <= unr_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/wsh_shift_reg.sv
`timescale 1ns/1ps
module wsh_shift_reg #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] d,
  output logic              sout
);
  logic [WORD_W-1:0] q, nxt;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == WORD_W - 1) begin : g_top
      always_comb begin
        if (load)       nxt[i] = d[i];
        else if (shift) nxt[i] = 1'b0;
        else            nxt[i] = q[i];
      end
    end else begin : g_mid
      always_comb begin
        if (load)       nxt[i] = d[i];
        else if (shift) nxt[i] = q[i+1];
        else            nxt[i] = q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (load || shift)  q <= nxt;
  end

  assign sout = q[0];
endmodule

// File: rtl/wsh_par_stage.sv
`timescale 1ns/1ps
module wsh_par_stage #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              par_mode,
  input  logic              strobe,
  input  logic              nonempty,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] d,
  output logic              load,
  output logic [WORD_W-1:0] pdata,
  output logic              pvalid
);
  logic [WORD_W-1:0] word_q;
  logic              held_q;

  assign load = run && par_mode && strobe && nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      held_q <= 1'b0;
    end else if (load) begin
      word_q <= d;
      held_q <= 1'b1;
    end
  end

  assign pvalid = par_mode && held_q && !oe_n;
  assign pdata  = pvalid ? word_q : '0;
endmodule

// File: rtl/wsh_word_shifter.sv
`timescale 1ns/1ps
module wsh_word_shifter #(
  parameter  int unsigned WORD_W = 9,
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              oe_n,
  input  logic              sclk_en,
  input  logic              casc_in,
  input  logic [CNT_W-1:0]  width_sel,
  input  logic              fifo_nonempty,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_req,
  output logic              ser_out,
  output logic              underrun,
  output logic              casc_out,
  output logic [WORD_W-1:0] par_data,
  output logic              par_valid
);
  import wsh_pkg::*;

  wsh_mode_e        mode;
  logic             run;
  logic             ser_mode;
  logic             step;
  logic [CNT_W-1:0] width;
  logic             ser_load, ser_shift, last_bit;
  logic             par_load;

  assign mode     = wsh_mode_e'(par_mode);
  assign ser_mode = (mode == WSH_SERIAL);
  assign step     = sclk_en && casc_in;

  wsh_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (run)
  );

  wsh_width_dec #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_width_dec (
    .code  (width_sel),
    .width (width)
  );

  wsh_ser_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_ser_ctrl (
    .clk      (clk),
    .rst_n    (run),
    .run      (run),
    .ser_mode (ser_mode),
    .step     (step),
    .nonempty (fifo_nonempty),
    .width    (width),
    .load     (ser_load),
    .shift    (ser_shift),
    .last_bit (last_bit),
    .underrun (underrun)
  );

  wsh_shift_reg #(.WORD_W(WORD_W)) i_shift_reg (
    .clk   (clk),
    .rst_n (run),
    .load  (ser_load),
    .shift (ser_shift),
    .d     (rd_data),
    .sout  (ser_out)
  );

  wsh_par_stage #(.WORD_W(WORD_W)) i_par_stage (
    .clk      (clk),
    .rst_n    (run),
    .run      (run),
    .par_mode (!ser_mode),
    .strobe   (sclk_en),
    .nonempty (fifo_nonempty),
    .oe_n     (oe_n),
    .d        (rd_data),
    .load     (par_load),
    .pdata    (par_data),
    .pvalid   (par_valid)
  );

  assign rd_req   = ser_load || par_load;
  assign casc_out = ser_mode && last_bit;
endmodule

// File: rtl/wsh_word_shifter_chk.sv
`timescale 1ns/1ps
module wsh_word_shifter_chk #(
  parameter int unsigned WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              par_mode,
  input logic              oe_n,
  input logic              sclk_en,
  input logic              fifo_nonempty,
  input logic              rd_req,
  input logic              ser_out,
  input logic              underrun,
  input logic [WORD_W-1:0] par_data,
  input logic              par_valid
);
  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> fifo_nonempty); // R5

  AST_BUS_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!par_valid && par_data == '0)); // R10

  AST_PAR_POP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && rd_req) |-> sclk_en); // R9

  AST_STARVED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && $past(underrun)) |-> $stable(ser_out)); // R6

  AST_PAR_FREEZES_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_mode) |-> $stable(ser_out)); // R11
endmodule

bind wsh_word_shifter wsh_word_shifter_chk #(.WORD_W(WORD_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .par_mode      (par_mode),
  .oe_n          (oe_n),
  .sclk_en       (sclk_en),
  .fifo_nonempty (fifo_nonempty),
  .rd_req        (rd_req),
  .ser_out       (ser_out),
  .underrun      (underrun),
  .par_data      (par_data),
  .par_valid     (par_valid)
);

// File: tb/test_wsh_word_shifter.sv
`timescale 1ns/1ps
module test_wsh_word_shifter;
  logic       clk = 1'b0;
  logic       rst_n, par_mode, oe_n, sclk_en, casc_in;
  logic [3:0] width_sel;
  logic       fifo_nonempty;
  logic [8:0] rd_data;
  logic       rd_req, ser_out, underrun, casc_out, par_valid;
  logic [8:0] par_data;

  int nvec = 0;
  int nfail = 0;
  logic [8:0] mem [0:63];
  int wp = 0;
  int rp;
  int pops;

  always #2.5 clk = ~clk;

  wsh_word_shifter i_wsh_word_shifter (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .oe_n(oe_n),
    .sclk_en(sclk_en), .casc_in(casc_in), .width_sel(width_sel),
    .fifo_nonempty(fifo_nonempty), .rd_data(rd_data), .rd_req(rd_req),
    .ser_out(ser_out), .underrun(underrun), .casc_out(casc_out),
    .par_data(par_data), .par_valid(par_valid)
  );

  assign fifo_nonempty = (wp != rp);
  assign rd_data       = mem[rp[5:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp   <= 0;
      pops <= 0;
    end else if (rd_req) begin
      rp   <= rp + 1;
      pops <= pops + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] w);
    mem[wp[5:0]] = w;
    wp++;
  endtask

  task automatic pulse();
    sclk_en = 1'b1;
    @(negedge clk);
    sclk_en = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; sclk_en = 1'b0; par_mode = 1'b0; oe_n = 1'b0;
    casc_in = 1'b1; width_sel = 4'd9; wp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R1 rd_req", rd_req, 0);
    chk("R1 ser_out", ser_out, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 casc_out", casc_out, 0);
    chk("R1 par_valid", par_valid, 0);
    push(9'h1FF);
    @(negedge clk);
    chk("R2 loaded bit0", ser_out, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async clear ser_out", ser_out, 0);
    chk("R1 async clear rd_req", rd_req, 0);
    @(negedge clk);
  endtask

  task automatic t_serial(input logic [3:0] code, input int w);
    logic [8:0] words [0:2];
    words[0] = 9'h1A5; words[1] = 9'h0F3; words[2] = 9'h15A;
    apply_reset();
    width_sel = code;
    oe_n = 1'b1;
    for (int k = 0; k < 3; k++) push(words[k]);
    @(negedge clk);
    chk("R2 first pop", pops, 1);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < w; i++) begin
        if (!(k == 0 && i == 0)) pulse();
        chk("R3 bit order", ser_out, words[k][i]);
        chk("R8 last-bit marker", casc_out, (i == w - 1) ? 1 : 0);
      end
    end
    chk("R4 one pop per word", pops, 3);
    chk("R10 serial ignores oe_n / bus off", par_valid, 0);
    chk("R6 no underrun yet", underrun, 0);
    pulse();
    chk("R6 underrun set", underrun, 1);
    chk("R6 output held", ser_out, words[2][w-1]);
    pulse();
    chk("R6 still held", ser_out, words[2][w-1]);
    push(9'h0AB);
    @(negedge clk);
    chk("R6 underrun cleared", underrun, 0);
    chk("R2 reload bit0", ser_out, 1);
    chk("R5 pops after refill", pops, 4);
  endtask

  task automatic t_cascade();
    apply_reset();
    width_sel = 4'd3;
    push(9'h006);
    @(negedge clk);
    casc_in = 1'b0;
    pulse(); pulse(); pulse();
    chk("R7 stalled output", ser_out, 0);
    chk("R7 no pop", pops, 1);
    chk("R7 not at last bit", casc_out, 0);
    casc_in = 1'b1;
    width_sel = 4'd9;
    pulse();
    chk("R3 bit1", ser_out, 1);
    pulse();
    chk("R4 latched width ends word", casc_out, 1);
    chk("R3 bit2", ser_out, 1);
    pulse();
    chk("R6 underrun after latched width", underrun, 1);
  endtask

  task automatic t_parallel();
    apply_reset();
    par_mode = 1'b1;
    push(9'h155); push(9'h0CC);
    repeat (2) @(negedge clk);
    chk("R9 no load without strobe", pops, 0);
    chk("R10 nothing held", par_valid, 0);
    pulse();
    chk("R9 first word valid", par_valid, 1);
    chk("R9 first word", par_data, 9'h155);
    chk("R11 serial untouched", ser_out, 0);
    pulse();
    chk("R9 second word", par_data, 9'h0CC);
    pulse();
    chk("R9 empty strobe keeps word", par_data, 9'h0CC);
    chk("R9 empty strobe no pop", pops, 2);
    oe_n = 1'b1;
    @(negedge clk);
    chk("R10 disabled valid", par_valid, 0);
    chk("R10 disabled data", par_data, 0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R10 re-enabled", par_data, 9'h0CC);
  endtask

  initial begin
    #(100000 * 5);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_serial(4'd4, 4);
    t_serial(4'd0, 1);
    t_serial(4'd15, 9);
    t_cascade();
    t_parallel();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule